// File: doc/BRIEF.md
# PS/2 Serial Frame Receiver

This block takes the two open-collector lines of a PS/2 mouse or keyboard, already brought on chip as plain logic inputs, and turns the serial stream into bytes. Both lines cross into the system clock domain through two-flop synchronisers. The clock line is then debounced by a filter that accepts a new level only after it has been stable for a set number of system cycles. Each accepted high-to-low transition of the device clock samples one data bit.

Eleven sampled bits make one frame. The frame is judged as a whole. A frame is good when it opens with a 0 start bit, closes with a 1 stop bit, and has an odd count of ones across the eight data bits and the parity bit. A good frame updates the byte output and raises a valid strobe for one system clock. A bad frame leaves the byte output alone and raises an error strobe for one cycle. If the device clock stops in the middle of a frame for longer than a set number of system cycles, the partial frame is dropped and the receiver waits for a fresh start bit.

Top module: `ps2_frame_rx`

## Requirements
- R1: During and right after synchronous reset, `rx_valid_o` and `rx_err_o` are 0 and `rx_byte_o` is 8'h00.
- R2: A frame sent as start(0), D0..D7 least significant bit first, odd parity, stop(1) produces `rx_byte_o` equal to D7..D0 and a `rx_valid_o` pulse exactly one system cycle wide.
- R3: `rx_byte_o` keeps its value from one good frame until the next good frame, including across bad frames.
- R4: A frame whose parity bit makes the ones count of data plus parity even gives one `rx_err_o` pulse and no `rx_valid_o` pulse.
- R5: A frame whose first bit is 1 gives one `rx_err_o` pulse and no `rx_valid_o` pulse.
- R6: A frame whose eleventh bit is 0 gives one `rx_err_o` pulse and no `rx_valid_o` pulse.
- R7: When at least one bit of a frame has been taken and no further falling edge follows within TIMEOUT_CYC system cycles, the partial frame is discarded, so a complete frame sent afterwards is received correctly with no error pulse.
- R8: A low pulse on the device clock line that lasts fewer than FILT_LEN system cycles is not counted as a falling edge.
- R9: `rx_valid_o` and `rx_err_o` are never high in the same cycle, and neither stays high for two cycles in a row.
- R10: Changes on the data line while the device clock stays high produce no strobe and do not change `rx_byte_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ps2_clk_i | input | 1 | Device clock line, rests high |
| ps2_dat_i | input | 1 | Device data line |
| rx_byte_o | output | 8 | Last good byte received |
| rx_valid_o | output | 1 | One-cycle strobe: new good byte on rx_byte_o |
| rx_err_o | output | 1 | One-cycle strobe: a frame failed its start, stop or parity check |

## Verification
A bit counter that is off by one shows up as a misaligned frame. The next frame then turns into an error pulse or a wrong byte within about eleven device clock periods. The timeout scenario relies on this: it leaves five stray bits behind, and a receiver that failed to drop them would corrupt the frame that follows. A filter that accepted short glitches would insert an extra bit, and the error would show up as soon as that frame finished. Strobe width and exclusivity are watched every cycle, so a stuck strobe is reported one cycle after it appears.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

    localparam int FRAME_BITS = 11;
    localparam int DATA_BITS  = 8;

    // Packed so that the first received bit lands in bit 0.
    typedef struct packed {
        logic                 stop;
        logic                 parity;
        logic [DATA_BITS-1:0] data;
        logic                 start;
    } frame_t;

    typedef struct packed {
        logic                 valid;
        logic                 err;
        logic [DATA_BITS-1:0] data;
    } verdict_t;

    function automatic logic odd_parity_ok(input frame_t f);
        return ^{f.data, f.parity};
    endfunction

    function automatic logic frame_good(input frame_t f);
        return (f.start == 1'b0) && (f.stop == 1'b1) && odd_parity_ok(f);
    endfunction

endpackage

// File: rtl/ps2_line_cond.sv
module ps2_line_cond #(
    parameter int FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic ps2_clk_i,
    input  logic ps2_dat_i,
    output logic fall_o,
    output logic bit_o
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic [1:0]    ck_sync;
    logic [1:0]    dt_sync;
    logic          filt;
    logic [CW-1:0] cnt;
    logic          flip;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_sync <= 2'b11;
            dt_sync <= 2'b11;
        end else begin
            ck_sync <= {ck_sync[0], ps2_clk_i};
            dt_sync <= {dt_sync[0], ps2_dat_i};
        end
    end

    // New level accepted only after FILT_LEN consecutive differing samples.
    assign flip = (ck_sync[1] != filt) && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            filt   <= 1'b1;
            cnt    <= '0;
            fall_o <= 1'b0;
            bit_o  <= 1'b0;
        end else begin
            fall_o <= flip && filt;
            if (flip && filt)
                bit_o <= dt_sync[1];
            if (ck_sync[1] == filt) begin
                cnt <= '0;
            end else if (flip) begin
                filt <= ck_sync[1];
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ps2_bit_collect.sv
module ps2_bit_collect
    import ps2rx_pkg::*;
#(
    parameter int TIMEOUT_CYC = 12500
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   fall_i,
    input  logic   bit_i,
    output logic   done_o,
    output frame_t frame_o
);
    localparam int IW = $clog2(FRAME_BITS);
    localparam int GW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(FRAME_BITS - 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(TIMEOUT_CYC - 1);

    logic [FRAME_BITS-1:0] shreg;
    logic [IW-1:0]         idx;
    logic [GW-1:0]         gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            idx    <= '0;
            gap    <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (fall_i) begin
                shreg <= {bit_i, shreg[FRAME_BITS-1:1]};
                gap   <= '0;
                if (idx == IDX_LAST) begin
                    idx    <= '0;
                    done_o <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end else if (idx != '0) begin
                if (gap == GAP_LAST) begin
                    idx <= '0;
                    gap <= '0;
                end else begin
                    gap <= gap + 1'b1;
                end
            end else begin
                gap <= '0;
            end
        end
    end

    assign frame_o = frame_t'(shreg);

endmodule

// File: rtl/ps2_frame_judge.sv
module ps2_frame_judge
    import ps2rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 done_i,
    input  frame_t               frame_i,
    output logic [DATA_BITS-1:0] byte_o,
    output logic                 valid_o,
    output logic                 err_o
);
    verdict_t v;

    always_ff @(posedge clk) begin
        if (rst) begin
            v <= '0;
        end else begin
            v.valid <= 1'b0;
            v.err   <= 1'b0;
            if (done_i) begin
                if (frame_good(frame_i)) begin
                    v.valid <= 1'b1;
                    v.data  <= frame_i.data;
                end else begin
                    v.err <= 1'b1;
                end
            end
        end
    end

    assign byte_o  = v.data;
    assign valid_o = v.valid;
    assign err_o   = v.err;

endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
    import ps2rx_pkg::*;
#(
    parameter int FILT_LEN    = 8,
    parameter int TIMEOUT_CYC = 12500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    output logic [7:0] rx_byte_o,
    output logic       rx_valid_o,
    output logic       rx_err_o
);
    logic   fall;
    logic   sbit;
    logic   done;
    frame_t frame;

    ps2_line_cond #(.FILT_LEN(FILT_LEN)) u_cond (
        .clk       (clk),
        .rst       (rst),
        .ps2_clk_i (ps2_clk_i),
        .ps2_dat_i (ps2_dat_i),
        .fall_o    (fall),
        .bit_o     (sbit)
    );

    ps2_bit_collect #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_coll (
        .clk     (clk),
        .rst     (rst),
        .fall_i  (fall),
        .bit_i   (sbit),
        .done_o  (done),
        .frame_o (frame)
    );

    ps2_frame_judge u_judge (
        .clk     (clk),
        .rst     (rst),
        .done_i  (done),
        .frame_i (frame),
        .byte_o  (rx_byte_o),
        .valid_o (rx_valid_o),
        .err_o   (rx_err_o)
    );

endmodule

// File: rtl/ps2_frame_rx_chk.sv
module ps2_frame_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       fall,
    input logic       done,
    input logic [7:0] rx_byte_o,
    input logic       rx_valid_o,
    input logic       rx_err_o
);
    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid_o && rx_err_o));

    // R9
    valid_width_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid_o |=> !rx_valid_o);

    // R9
    err_width_chk: assert property (@(posedge clk) disable iff (rst)
        rx_err_o |=> !rx_err_o);

    // R3
    byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_valid_o |-> $stable(rx_byte_o));

    // R2
    valid_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_o || rx_err_o) |-> $past(done));

    // R8
    edge_single_chk: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

bind ps2_frame_rx ps2_frame_rx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .fall       (fall),
    .done       (done),
    .rx_byte_o  (rx_byte_o),
    .rx_valid_o (rx_valid_o),
    .rx_err_o   (rx_err_o)
);

// File: tb/tb_ps2_frame_rx.sv
`timescale 1ns/1ps
module tb_ps2_frame_rx;
    localparam int FILT = 4;
    localparam int TMO  = 300;
    localparam int HALF = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pclk = 1'b1;
    logic       pdat = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       rx_err;

    int n_total = 0;
    int n_pass  = 0;
    int n_valid = 0;
    int n_err   = 0;
    int n_wide  = 0;
    bit prev_v  = 1'b0;
    bit prev_e  = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ps2_frame_rx #(.FILT_LEN(FILT), .TIMEOUT_CYC(TMO)) dut (
        .clk        (clk),
        .rst        (rst),
        .ps2_clk_i  (pclk),
        .ps2_dat_i  (pdat),
        .rx_byte_o  (rx_byte),
        .rx_valid_o (rx_valid),
        .rx_err_o   (rx_err)
    );

    // Monitor away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) n_valid++;
            if (rx_err) n_err++;
            if ((rx_valid && prev_v) || (rx_err && prev_e) || (rx_valid && rx_err))
                n_wide++;
        end
        prev_v = rx_valid;
        prev_e = rx_err;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_total++;
        if (ok) n_pass++;
        else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // bits: number of bits to send (11 for a full frame); glitch_bit >= 0
    // inserts a 2-cycle low pulse during that bit's high phase.
    task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_start,
                        input bit bad_stop, input int bits, input int glitch_bit);
        logic [10:0] fr;
        fr[0]   = bad_start;
        fr[8:1] = d;
        fr[9]   = ~(^d) ^ bad_par;
        fr[10]  = ~bad_stop;
        for (int i = 0; i < bits; i++) begin
            pdat = fr[i];
            if (i == glitch_bit) begin
                wait_cyc(5);
                pclk = 1'b0;
                wait_cyc(2);
                pclk = 1'b1;
                wait_cyc(HALF/2 - 7);
            end else begin
                wait_cyc(HALF/2);
            end
            pclk = 1'b0;
            wait_cyc(HALF);
            pclk = 1'b1;
            wait_cyc(HALF/2);
        end
        pdat = 1'b1;
    endtask

    task automatic t_good(input logic [7:0] d, input string tag);
        int v0 = n_valid, e0 = n_err;
        send(d, 0, 0, 0, 11, -1);
        wait_cyc(60);
        chk(rx_byte == d, "R2", {tag, " byte"}, rx_byte, d);
        chk(n_valid - v0 == 1 && n_err == e0, "R2", {tag, " one valid, no err"},
            n_valid - v0, 1);
    endtask

    task automatic t_bad(input logic [7:0] d, input bit bp, input bit bs, input bit bt,
                         input string req);
        logic [7:0] keep = rx_byte;
        int v0 = n_valid, e0 = n_err;
        send(d, bp, bs, bt, 11, -1);
        wait_cyc(60);
        chk(n_err - e0 == 1, req, "one error pulse", n_err - e0, 1);
        chk(n_valid == v0, req, "no valid pulse", n_valid - v0, 0);
        chk(rx_byte == keep, "R3", "byte held over bad frame", rx_byte, keep);
    endtask

    task automatic t_reset;
        wait_cyc(1);
        chk(rx_valid == 0 && rx_err == 0, "R1", "strobes in reset",
            {rx_valid, rx_err}, 0);
        chk(rx_byte == 8'h00, "R1", "byte in reset", rx_byte, 0);
        rst = 1'b0;
        wait_cyc(20);
        chk(rx_byte == 8'h00 && n_valid == 0 && n_err == 0, "R1", "after reset",
            rx_byte, 0);
    endtask

    task automatic t_timeout;
        int v0, e0;
        send(8'h77, 0, 0, 0, 5, -1);
        wait_cyc(TMO + 100);
        v0 = n_valid; e0 = n_err;
        send(8'h5A, 0, 0, 0, 11, -1);
        wait_cyc(60);
        chk(rx_byte == 8'h5A, "R7", "byte after timeout", rx_byte, 8'h5A);
        chk(n_valid - v0 == 1 && n_err == e0, "R7", "clean frame after timeout",
            n_err - e0, 0);
    endtask

    task automatic t_glitch;
        int v0 = n_valid, e0 = n_err;
        send(8'h81, 0, 0, 0, 11, 4);
        wait_cyc(60);
        chk(rx_byte == 8'h81, "R8", "byte with clock glitch", rx_byte, 8'h81);
        chk(n_valid - v0 == 1 && n_err == e0, "R8", "glitch ignored",
            n_err - e0, 0);
    endtask

    task automatic t_idle_data;
        logic [7:0] keep = rx_byte;
        int v0 = n_valid, e0 = n_err;
        for (int i = 0; i < 10; i++) begin
            pdat = ~pdat;
            wait_cyc(30);
        end
        pdat = 1'b1;
        wait_cyc(TMO + 50);
        chk(n_valid == v0 && n_err == e0, "R10", "no strobe on idle data",
            n_valid - v0 + n_err - e0, 0);
        chk(rx_byte == keep, "R10", "byte unchanged on idle data", rx_byte, keep);
    endtask

    initial begin
        wait_cyc(5);
        t_reset();
        t_good(8'hA5, "R2 A5");
        t_good(8'h00, "R2 00");
        t_good(8'hFF, "R2 FF");
        t_good(8'h3C, "R2 3C");
        t_bad(8'h12, 1, 0, 0, "R4");
        t_bad(8'h34, 0, 1, 0, "R5");
        t_bad(8'h56, 0, 0, 1, "R6");
        t_timeout();
        t_glitch();
        t_idle_data();
        t_good(8'h01, "R3 next byte");
        chk(n_wide == 0, "R9", "strobe overlap or width", n_wide, 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(0, "R2", "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

endmodule